// File: doc/BRIEF.md
# Soft-Start Ready Timer

This block holds a charge-pump boost regulator in a gentle start-up mode for a fixed time after power-on, then raises a ready flag and hands the pump tiles to load-based control. After the power-on reset is released, a chain of nine binary stages counts clock cycles. When the top stage sets, the chain stops counting on its own. The ready flag then stays asserted until the next power-on reset. With a 200 MHz clock the wait is 2^8 = 256 cycles, or 1.28 µs.

While the flag is low, every switchable tile enable is forced off, whatever the load controller requests. Only the first 16 of the 32 always-on pump units run. Once the flag is high, each tile enable follows its request bit from the load controller, and all 32 always-on units are enabled. A bypass input ORs into the flag, so the regulator can skip the soft start entirely. The bypass input does not disturb the timer.

Top module: `softstart_ready_timer`

## Requirements
- R1: While `rst_n` is low, the timer is cleared at once, without waiting for a clock edge. With `bypass` low this gives `ok` = 0 and `tile_en` = 0.
- R2: With `bypass` low, `ok` reads 1 after the 256th rising clock edge that `rst_n` is high for. This count is 2^(STAGES-1) with STAGES = 9.
- R3: With `bypass` low, `ok` reads 0 after the 255th such edge and after every earlier one.
- R4: Once the timer has expired, `ok` stays 1 on every later cycle until `rst_n` falls. This holds whatever `tile_req` and `bypass` do.
- R5: `ok` is 1 in any cycle where `bypass` is 1, including during reset and before the timer expires. The path from `bypass` to `ok` is combinational.
- R6: Pulsing `bypass` before expiry does not change the timing. When `bypass` drops, `ok` returns to 0, and it still rises after the 256th edge.
- R7: While `ok` is 0, `tile_en` is all zeros for every value of `tile_req`.
- R8: While `ok` is 0, `aon_en` equals 32'h0000_FFFF. Bits 15:0, the soft-start units, are on and bits 31:16 are off.
- R9: While `ok` is 1, `tile_en` equals `tile_req` bit for bit, and `aon_en` is all ones.
- R10: Asserting `rst_n` low again after expiry restarts the full 256-edge wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz timer clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bypass | input | 1 | Forces the ready flag high immediately |
| tile_req | input | 8 | Per-tile enable requests from the load controller |
| ok | output | 1 | Regulator ready flag |
| tile_en | output | 8 | Gated tile enables |
| aon_en | output | 32 | Always-on pump unit enables |

## Verification
The bench goes after the exact edge of expiry by checking `ok` after edges 255 and 256. An off-by-one terminal count, or a chain that counts from the wrong start value, moves the rise by a cycle and is caught there. It pulses `bypass` mid-count and watches `ok` fall back and still rise on time. A design that latched the bypass, or reset the chain from it, would stay high or rise late. Long runs after expiry with `bypass` toggling expose a chain that keeps counting and wraps, which would make `ok` drop. Changing `tile_req` during soft start exposes enables that leak through before ready. A second reset after expiry shows whether the wait restarts in full.

// File: rtl/sst_pkg.sv
package sst_pkg;

  // Cycles from reset release until the final stage sets.
  function automatic int unsigned ready_delay_cycles(input int unsigned stages);
    return 32'd1 << (stages - 1);
  endfunction

  // True when always-on unit 'idx' belongs to the soft-start subset.
  function automatic bit is_soft_unit(input int unsigned idx, input int unsigned soft_units);
    return idx < soft_units;
  endfunction

endpackage

// File: rtl/sst_delay_chain.sv
module sst_delay_chain #(
  parameter int unsigned STAGES = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [STAGES-1:0] cnt_q,
  output logic              chain_run,
  output logic              chain_done
);
  logic [STAGES-1:0] carry;
  logic [STAGES-1:0] cnt_d;

  // Counting stops once the top stage has set.
  assign chain_run  = ~cnt_q[STAGES-1];
  assign chain_done = cnt_q[STAGES-1];
  assign carry[0]   = chain_run;

  // Each stage toggles when every stage below it is 1 (synchronous divide-by-two chain).
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign cnt_d[i] = cnt_q[i] ^ carry[i];
    if (i < STAGES - 1) begin : g_carry
      assign carry[i+1] = carry[i] & cnt_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sst_ready_flag.sv
module sst_ready_flag (
  input  logic chain_done,
  input  logic bypass,
  output logic ok
);
  assign ok = chain_done | bypass;
endmodule

// File: rtl/sst_pump_gate.sv
module sst_pump_gate #(
  parameter int unsigned TILES      = 8,
  parameter int unsigned AON_UNITS  = 32,
  parameter int unsigned SOFT_UNITS = 16
) (
  input  logic                 ok,
  input  logic [TILES-1:0]     tile_req,
  output logic [TILES-1:0]     tile_en,
  output logic [AON_UNITS-1:0] aon_en
);
  for (genvar t = 0; t < TILES; t++) begin : g_tile
    assign tile_en[t] = ok & tile_req[t];
  end

  for (genvar u = 0; u < AON_UNITS; u++) begin : g_aon
    if (sst_pkg::is_soft_unit(u, SOFT_UNITS)) begin : g_soft
      assign aon_en[u] = 1'b1;
    end else begin : g_late
      assign aon_en[u] = ok;
    end
  end
endmodule

// File: rtl/softstart_ready_timer.sv
module softstart_ready_timer #(
  parameter int unsigned STAGES     = 9,
  parameter int unsigned TILES      = 8,
  parameter int unsigned AON_UNITS  = 32,
  parameter int unsigned SOFT_UNITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bypass,
  input  logic [TILES-1:0]     tile_req,
  output logic                 ok,
  output logic [TILES-1:0]     tile_en,
  output logic [AON_UNITS-1:0] aon_en
);
  // Internal events brought out for the checker.
  logic [STAGES-1:0] cnt_q;
  logic              chain_run;
  logic              chain_done;

  sst_delay_chain #(.STAGES(STAGES)) chain_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_q      (cnt_q),
    .chain_run  (chain_run),
    .chain_done (chain_done)
  );

  sst_ready_flag flag_i (
    .chain_done (chain_done),
    .bypass     (bypass),
    .ok         (ok)
  );

  sst_pump_gate #(
    .TILES      (TILES),
    .AON_UNITS  (AON_UNITS),
    .SOFT_UNITS (SOFT_UNITS)
  ) gate_i (
    .ok       (ok),
    .tile_req (tile_req),
    .tile_en  (tile_en),
    .aon_en   (aon_en)
  );
endmodule

// File: rtl/sst_ready_chk.sv
module sst_ready_chk #(
  parameter int unsigned STAGES     = 9,
  parameter int unsigned TILES      = 8,
  parameter int unsigned AON_UNITS  = 32,
  parameter int unsigned SOFT_UNITS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bypass,
  input logic [TILES-1:0]     tile_req,
  input logic                 ok,
  input logic [TILES-1:0]     tile_en,
  input logic [AON_UNITS-1:0] aon_en,
  input logic [STAGES-1:0]    cnt_q,
  input logic                 chain_run,
  input logic                 chain_done
);
  localparam int unsigned DELAY = sst_pkg::ready_delay_cycles(STAGES);

  // Independent count of edges since reset release, saturating at DELAY.
  logic [STAGES:0] elapsed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                elapsed_q <= '0;
    else if (elapsed_q < (STAGES+1)'(DELAY))   elapsed_q <= elapsed_q + 1'b1;
  end

  // R2
  delay_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed_q == (STAGES+1)'(DELAY)) |-> (chain_done && !chain_run));

  // R3
  delay_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed_q < (STAGES+1)'(DELAY)) |-> !chain_done);

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> (chain_done && $stable(cnt_q) && ok));

  // R5
  bypass_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> ok);

  // R7
  tiles_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok |-> (tile_en == '0));

  // R8
  soft_aon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok |-> ($countones(aon_en) == SOFT_UNITS && aon_en[0]));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (tile_en == tile_req && aon_en == '1));
endmodule

bind softstart_ready_timer sst_ready_chk #(
  .STAGES     (STAGES),
  .TILES      (TILES),
  .AON_UNITS  (AON_UNITS),
  .SOFT_UNITS (SOFT_UNITS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bypass     (bypass),
  .tile_req   (tile_req),
  .ok         (ok),
  .tile_en    (tile_en),
  .aon_en     (aon_en),
  .cnt_q      (cnt_q),
  .chain_run  (chain_run),
  .chain_done (chain_done)
);

// File: tb/softstart_ready_timer_tb_top.sv
module softstart_ready_timer_tb_top;
  localparam int STAGES = 9;
  localparam int TILES  = 8;
  localparam int AON    = 32;
  localparam int SOFT   = 16;
  localparam int WAIT   = 256; // 2^(9-1) edges

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bypass = 1'b0;
  logic [TILES-1:0] tile_req = '0;
  logic             ok;
  logic [TILES-1:0] tile_en;
  logic [AON-1:0]   aon_en;

  int checks   = 0;
  int failures = 0;
  int edges    = 0;
  bit finished = 0;

  typedef struct {
    string            tag;
    logic             ok;
    logic [TILES-1:0] tile_en;
    logic [AON-1:0]   aon_en;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk; // 200 MHz

  softstart_ready_timer #(.STAGES(STAGES), .TILES(TILES), .AON_UNITS(AON), .SOFT_UNITS(SOFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .tile_req(tile_req),
    .ok(ok), .tile_en(tile_en), .aon_en(aon_en)
  );

  // Bench's own edge count since reset release.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  // Driver side: compute the expectation from the requirements and queue it.
  task automatic expect_now(input string tag);
    exp_t e;
    logic rdy;
    rdy = (rst_n && edges >= WAIT) || bypass;
    e.tag     = tag;
    e.ok      = rdy;
    e.tile_en = rdy ? tile_req : '0;
    e.aon_en  = rdy ? '1 : {{(AON-SOFT){1'b0}}, {SOFT{1'b1}}};
    sb_q.push_back(e);
  endtask

  // Monitor: compare at the falling edge, away from the active edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (ok !== e.ok || tile_en !== e.tile_en || aon_en !== e.aon_en) begin
        failures++;
        $display("FAIL %s: ok=%b tile_en=%h aon_en=%h expected ok=%b tile_en=%h aon_en=%h",
                 e.tag, ok, tile_en, aon_en, e.ok, e.tile_en, e.aon_en);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run_to_ready(input string phase);
    for (int c = 1; c <= WAIT + 40; c++) begin
      step();
      tile_req = TILES'(c * 37 + 5);
      if (edges == WAIT - 1)     expect_now({phase, " R3 last edge before ready"});
      else if (edges == WAIT)    expect_now({phase, " R2 ready edge"});
      else if (edges < WAIT)     expect_now({phase, " R7 R8 soft start"});
      else                       expect_now({phase, " R9 released"});
    end
  endtask

  initial begin
    // R1: reset state
    tile_req = 8'hA5;
    step();
    expect_now("R1 reset state");
    step();
    bypass = 1'b1;
    expect_now("R5 bypass during reset");
    step();
    bypass = 1'b0;
    expect_now("R1 R7 R8 reset, requests blocked");
    step();
    rst_n = 1'b1;

    // Run with a bypass pulse mid-count (R5, R6)
    for (int c = 1; c <= WAIT + 40; c++) begin
      step();
      tile_req = TILES'(c * 53 + 1);
      bypass = (edges >= 100 && edges < 105);
      if (bypass)                 expect_now("R5 bypass forces ready");
      else if (edges == 105)      expect_now("R6 bypass released, back to soft start");
      else if (edges == WAIT - 1) expect_now("R6 R3 delay unchanged by bypass");
      else if (edges == WAIT)     expect_now("R6 R2 ready after bypass pulse");
      else if (edges < WAIT)      expect_now("R7 R8 soft start");
      else                        expect_now("R9 released");
    end

    // R4: sticky with bypass toggling and requests changing, long run
    for (int c = 0; c < 700; c++) begin
      step();
      bypass = c[2];
      tile_req = TILES'(c ^ (c >> 3));
      expect_now("R4 ready stays high");
    end
    bypass = 1'b0;

    // Asynchronous reset mid-cycle (R1)
    @(posedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    checks++;
    if (ok !== 1'b0 || tile_en !== '0) begin
      failures++;
      $display("FAIL R1 async clear: ok=%b tile_en=%h expected ok=0 tile_en=00", ok, tile_en);
    end
    expect_now("R1 reset after ready");
    step();
    rst_n = 1'b1;

    // R10: full wait again
    run_to_ready("R10");

    step();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule